// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Reset Indication

This block moves data words from a write clock domain to an unrelated read clock domain. Words are stored in a small dual-port memory. The write and read positions are kept as binary counters that are one bit wider than the address. Each counter is sent to the opposite domain in Gray code through a chain of two flip-flops. The read side works as first-word-fall-through: the oldest stored word is already present on `rd_data` while `rd_valid` is high. Asserting `rd_en` in that state consumes the word.

The memory read register is clock-enabled only while the read side sees stored data. While the FIFO is empty, that register holds its value. A stale or still-settling memory cell therefore cannot reach `rd_data`.

Either domain reset clears the whole FIFO. The reset is asserted asynchronously in both domains and released synchronously in each one. The read side reports a reset on `rd_was_reset`. When `OUT_REG` is 1, an extra output register is added after the read side. In that configuration, `rd_was_reset` is delayed by the same read clock as `rd_valid` and `rd_data`, so all three stay aligned.

The read-side control is a state machine with four states:
- `RD_RESET`: held while the local reset is active.
- `RD_FLUSH`: entered on the first clock after reset release.
- `RD_EMPTY`: entered unconditionally after `RD_FLUSH`.
- `RD_VALID`: entered from `RD_EMPTY` or `RD_VALID` whenever the next read position differs from the synchronized write position. Otherwise the machine goes to, or stays in, `RD_EMPTY`.

The write-side control has two states:
- `WR_HOLD`: held during reset.
- `WR_RUN`: entered on the first clock after release.

Top module: `afifo_cdc_fwft`

## Requirements
- R1: After both resets are released, `wr_ready` is high and `rd_valid` is low while no word has been written.
- R2: A written word appears on `rd_data` with `rd_valid` high without any `rd_en` pulse. It stays there unchanged until it is consumed.
- R3: Words leave the read port in the order they were written, with their values intact, for any pattern of write gaps and read stalls.
- R4: After 2**`AW` words are stored with no reads, `wr_ready` is low. A write attempted while `wr_ready` is low is dropped, so exactly 2**`AW` words are read back before `rd_valid` falls.
- R5: `rd_en` asserted while `rd_valid` is low has no effect: the next word written is the next word read.
- R6: While `rd_valid` is low, `rd_data` does not change, because the memory read register is enabled only when data is available.
- R7: `rd_was_reset` is high during reset. After release of a reset on the read side, it stays high for exactly 3 read clocks when `OUT_REG` is 0. While it is high, `rd_valid` is low.
- R8: Asserting either `wr_rst` or `rd_rst` clears the whole FIFO. `wr_ready` drops in the write domain and `rd_was_reset` rises in the read domain. Words stored before the reset are never delivered.
- R9: With `OUT_REG` = 1, data keeps write order and `rd_was_reset` stays high for exactly 4 read clocks after release, one more than without the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain reset, active high; clears the whole FIFO |
| wr_en | input | 1 | Write strobe; taken only while wr_ready is high |
| wr_data | input | DW | Word to store |
| wr_ready | output | 1 | FIFO can accept a word this write clock |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain reset, active high; clears the whole FIFO |
| rd_en | input | 1 | Consume the word shown on rd_data |
| rd_data | output | DW | Oldest stored word (first-word-fall-through) |
| rd_valid | output | 1 | rd_data holds a stored word |
| rd_was_reset | output | 1 | FIFO has been reset; aligned with rd_valid and rd_data |

## Verification
The assertions check these properties on every clock:
- The write counter never gets more than 2**`AW` entries ahead of the synchronized read counter, and it does not move while `wr_ready` is low.
- The read counter does not move while `rd_valid` is low.
- `rd_data` holds while no data is valid.
- `rd_was_reset` and `rd_valid` are never high together.

Some behaviour can only be shown by the bench scenarios:
- Data order and integrity across unrelated clocks, under sweeps of write-gap and read-stall patterns.
- The exact number of read clocks that the reset flag stays high in each output variant.
- That words stored before a reset are lost.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
    typedef enum logic [1:0] {
        RD_RESET = 2'd0,
        RD_FLUSH = 2'd1,
        RD_EMPTY = 2'd2,
        RD_VALID = 2'd3
    } rd_state_e;

    typedef enum logic {
        WR_HOLD = 1'b0,
        WR_RUN  = 1'b1
    } wr_state_e;
endpackage

// File: rtl/afifo_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of a local reset.
module afifo_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic srst
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= '1;
        else      chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign srst = chain[STAGES-1];
endmodule

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a Gray-coded vector.
module afifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st <= '0;
        else     st <= {st[STAGES-2:0], d};
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
// Dual-port storage with a clock-enabled registered read port.
module afifo_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_din,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_ce,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_we) cells[wr_addr] <= wr_din;
    end

    always_ff @(posedge rd_clk or posedge rd_rst) begin
        if (rd_rst)     rd_q <= '0;
        else if (rd_ce) rd_q <= cells[rd_addr];
    end
endmodule

// File: rtl/afifo_wr_ctl.sv
`timescale 1ns/1ps
module afifo_wr_ctl
    import afifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rq_gray,
    output logic          push,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wgray,
    output logic          wr_ready
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wr_state_e st, st_n;
    logic [PW-1:0] wbin, wbin_n;
    logic full;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st <= WR_HOLD;
        else     st <= st_n;
    end

    always_comb begin
        unique case (st)
            WR_HOLD: st_n = WR_RUN;
            WR_RUN:  st_n = WR_RUN;
            default: st_n = WR_HOLD;
        endcase
    end

    assign full = (wgray == {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});

    always_comb begin
        unique case (st)
            WR_RUN:  wr_ready = ~full;
            default: wr_ready = 1'b0;
        endcase
    end

    assign push    = wr_en & wr_ready;
    assign wbin_n  = wbin + PW'(push);
    assign wr_addr = wbin[AW-1:0];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_n;
            wgray <= to_gray(wbin_n);
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wbin - from_gray(rq_gray)) <= PW'(DEPTH));

    // R4
    hold_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |=> $stable(wbin));
endmodule

// File: rtl/afifo_rd_ctl.sv
`timescale 1ns/1ps
module afifo_rd_ctl
    import afifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wq_gray,
    output logic          mem_ce,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rgray,
    output logic          rd_valid,
    output logic          rd_flag
);
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    rd_state_e st, st_n;
    logic [PW-1:0] rbin, rbin_n;
    logic active, pop, avail;

    assign active  = (st == RD_EMPTY) || (st == RD_VALID);
    assign pop     = rd_en && (st == RD_VALID);
    assign rbin_n  = rbin + PW'(pop);
    assign avail   = active && (to_gray(rbin_n) != wq_gray);
    assign mem_ce  = avail;
    assign rd_addr = rbin_n[AW-1:0];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st <= RD_RESET;
        else     st <= st_n;
    end

    always_comb begin
        unique case (st)
            RD_RESET: st_n = RD_FLUSH;
            RD_FLUSH: st_n = RD_EMPTY;
            RD_EMPTY: st_n = avail ? RD_VALID : RD_EMPTY;
            RD_VALID: st_n = avail ? RD_VALID : RD_EMPTY;
            default:  st_n = RD_RESET;
        endcase
    end

    always_comb begin
        unique case (st)
            RD_RESET, RD_FLUSH: begin rd_flag = 1'b1; rd_valid = 1'b0; end
            RD_EMPTY:           begin rd_flag = 1'b0; rd_valid = 1'b0; end
            RD_VALID:           begin rd_flag = 1'b0; rd_valid = 1'b1; end
            default:            begin rd_flag = 1'b1; rd_valid = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_n;
            rgray <= to_gray(rbin_n);
        end
    end

    // R5
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> $stable(rbin));
endmodule

// File: rtl/afifo_cdc_fwft.sv
`timescale 1ns/1ps
module afifo_cdc_fwft #(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter bit OUT_REG = 1'b0
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rd_was_reset
);
    localparam int PW      = AW + 1;
    localparam int SYNC_FF = 2;

    logic          any_rst, w_lrst, r_lrst;
    logic [PW-1:0] wgray, rgray, wgray_rd, rgray_wr;
    logic          push, mem_ce, in_valid, in_flag, inner_rd_en;
    logic [AW-1:0] w_addr, r_addr;
    logic [DW-1:0] mem_q;

    assign any_rst = wr_rst | rd_rst;

    afifo_rst_sync #(.STAGES(SYNC_FF)) u_wrst (.clk(wr_clk), .arst(any_rst), .srst(w_lrst));
    afifo_rst_sync #(.STAGES(SYNC_FF)) u_rrst (.clk(rd_clk), .arst(any_rst), .srst(r_lrst));

    afifo_sync #(.W(PW), .STAGES(SYNC_FF)) u_w2r (
        .clk(rd_clk), .rst(r_lrst), .d(wgray), .q(wgray_rd));
    afifo_sync #(.W(PW), .STAGES(SYNC_FF)) u_r2w (
        .clk(wr_clk), .rst(w_lrst), .d(rgray), .q(rgray_wr));

    afifo_wr_ctl #(.AW(AW)) u_wctl (
        .clk(wr_clk), .rst(w_lrst), .wr_en(wr_en), .rq_gray(rgray_wr),
        .push(push), .wr_addr(w_addr), .wgray(wgray), .wr_ready(wr_ready));

    afifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .wr_we(push), .wr_addr(w_addr), .wr_din(wr_data),
        .rd_clk(rd_clk), .rd_rst(r_lrst), .rd_ce(mem_ce), .rd_addr(r_addr), .rd_q(mem_q));

    afifo_rd_ctl #(.AW(AW)) u_rctl (
        .clk(rd_clk), .rst(r_lrst), .rd_en(inner_rd_en), .wq_gray(wgray_rd),
        .mem_ce(mem_ce), .rd_addr(r_addr), .rgray(rgray),
        .rd_valid(in_valid), .rd_flag(in_flag));

    if (OUT_REG == 1'b0) begin : g_direct
        assign inner_rd_en  = rd_en;
        assign rd_data      = mem_q;
        assign rd_valid     = in_valid;
        assign rd_was_reset = in_flag;
    end else begin : g_buffered
        logic [DW-1:0] ob_data;
        logic          ob_valid, ob_flag;

        assign inner_rd_en = !ob_valid || rd_en;

        always_ff @(posedge rd_clk or posedge r_lrst) begin
            if (r_lrst) begin
                ob_data  <= '0;
                ob_valid <= 1'b0;
                ob_flag  <= 1'b1;
            end else begin
                ob_flag  <= in_flag;
                ob_valid <= in_valid || (ob_valid && !rd_en);
                if (inner_rd_en && in_valid) ob_data <= mem_q;
            end
        end

        assign rd_data      = ob_data;
        assign rd_valid     = ob_valid;
        assign rd_was_reset = ob_flag;
    end

    // R6
    data_hold_chk: assert property (@(posedge rd_clk) disable iff (r_lrst)
        !rd_valid |=> (rd_valid || $stable(rd_data)));

    // R7
    flag_excludes_valid_chk: assert property (@(posedge rd_clk) disable iff (r_lrst)
        rd_was_reset |-> !rd_valid);
endmodule

// File: tb/tb_afifo_cdc_fwft.sv
`timescale 1ns/1ps
module tb_afifo_cdc_fwft;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    always #4   wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    logic          wr_rst = 1'b1, rd_rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic          wr_ready, rd_valid, rd_was_reset;

    logic          wr_rst_b = 1'b1, rd_rst_b = 1'b1, wr_en_b = 1'b0, rd_en_b = 1'b0;
    logic [DW-1:0] wr_data_b = '0, rd_data_b;
    logic          wr_ready_b, rd_valid_b, rd_was_reset_b;

    afifo_cdc_fwft #(.DW(DW), .AW(AW), .OUT_REG(1'b0)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_was_reset(rd_was_reset));

    afifo_cdc_fwft #(.DW(DW), .AW(AW), .OUT_REG(1'b1)) dut_b (
        .wr_clk(wr_clk), .wr_rst(wr_rst_b), .wr_en(wr_en_b), .wr_data(wr_data_b), .wr_ready(wr_ready_b),
        .rd_clk(rd_clk), .rd_rst(rd_rst_b), .rd_en(rd_en_b), .rd_data(rd_data_b), .rd_valid(rd_valid_b),
        .rd_was_reset(rd_was_reset_b));

    int n_tests = 0, n_fail = 0;
    logic [DW-1:0] sb [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_n(input int n, input int base, input bit gaps);
        int sent = 0;
        int guard = 0;
        while (sent < n && guard < 20000) begin
            @(negedge wr_clk);
            guard++;
            wr_en = 1'b0;
            if (!(gaps && (sent % 3 == 1) && (guard % 2 == 0)) && wr_ready) begin
                wr_data = DW'(base + sent * 29);
                wr_en   = 1'b1;
                sb.push_back(wr_data);
                sent++;
            end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic read_n(input int n, input int stallmod, input string req);
        int got = 0;
        int guard = 0;
        logic [DW-1:0] e;
        while (got < n && guard < 20000) begin
            @(negedge rd_clk);
            guard++;
            rd_en = 1'b0;
            if (rd_valid && !(stallmod > 0 && guard % stallmod == 0)) begin
                if (sb.size() == 0) begin
                    check(1'b0, req, rd_data, 0);
                end else begin
                    e = sb.pop_front();
                    check(rd_data == e, req, rd_data, e);
                end
                rd_en = 1'b1;
                got++;
            end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(got == n, req, got, n);
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 40 && !rd_valid; k++) @(negedge rd_clk);
    endtask

    // Watchdog
    initial begin
        #1500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        logic [DW-1:0] hold;

        // R1, R7: reset state and flag length
        repeat (4) @(negedge rd_clk);
        check(rd_was_reset == 1'b1, "R7 flag during reset", rd_was_reset, 1);
        check(rd_valid == 1'b0, "R1 valid during reset", rd_valid, 0);
        check(wr_ready == 1'b0, "R1 ready during reset", wr_ready, 0);
        @(negedge rd_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge rd_clk);
            if (rd_was_reset) cnt++;
        end
        check(cnt == 3, "R7 flag cycles after release", cnt, 3);
        repeat (3) @(negedge wr_clk);
        check(wr_ready == 1'b1, "R1 ready after reset", wr_ready, 1);
        check(rd_valid == 1'b0, "R1 empty after reset", rd_valid, 0);

        // R2: fall-through without rd_en
        write_n(1, 'hA5, 1'b0);
        wait_valid();
        check(rd_valid == 1'b1, "R2 valid without strobe", rd_valid, 1);
        check(rd_data == 8'hA5, "R2 head word", rd_data, 'hA5);
        repeat (5) @(negedge rd_clk);
        check(rd_valid == 1'b1 && rd_data == 8'hA5, "R2 head held", rd_data, 'hA5);
        read_n(1, 0, "R2 consume");

        // R6: data held while empty
        repeat (3) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R6 empty after consume", rd_valid, 0);
        hold = rd_data;
        repeat (10) @(negedge rd_clk);
        check(rd_data == hold, "R6 data stable while empty", rd_data, hold);

        // R5: read strobe while empty is ignored
        for (int k = 0; k < 6; k++) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(rd_valid == 1'b0, "R5 still empty", rd_valid, 0);
        write_n(1, 'h3C, 1'b0);
        read_n(1, 0, "R5 next word after empty reads");
        repeat (4) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R5 no extra word", rd_valid, 0);

        // R4: fill, dropped write, exact drain
        write_n(DEPTH, 'h01, 1'b0);
        check(wr_ready == 1'b0, "R4 ready low when full", wr_ready, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge wr_clk);
            wr_data = 8'hEE;
            wr_en   = 1'b1;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_ready == 1'b0, "R4 still full after dropped write", wr_ready, 0);
        read_n(DEPTH, 0, "R4 drain full");
        repeat (12) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R4 dropped write not stored", rd_valid, 0);

        // R3: streaming sweep over gap and stall patterns
        for (int p = 0; p < 6; p++) begin
            fork
                write_n(40, p * 50 + 7, (p % 2) == 1);
                read_n(40, (p >= 2) ? p : 0, "R3 stream order");
            join
        end
        check(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);

        // R8: write-side reset discards contents
        write_n(5, 'h40, 1'b0);
        wait_valid();
        @(negedge wr_clk);
        wr_rst = 1'b1;
        @(negedge rd_clk);
        check(rd_was_reset == 1'b1, "R8 flag on write reset", rd_was_reset, 1);
        check(rd_valid == 1'b0, "R8 valid cleared", rd_valid, 0);
        repeat (3) @(negedge wr_clk);
        wr_rst = 1'b0;
        sb.delete();
        repeat (12) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R8 contents discarded", rd_valid, 0);
        check(rd_was_reset == 1'b0, "R8 flag released", rd_was_reset, 0);
        write_n(1, 'h5A, 1'b0);
        read_n(1, 0, "R8 fresh word after reset");

        // R8: read-side reset also clears the write side
        @(negedge wr_clk);
        rd_rst = 1'b1;
        @(negedge wr_clk);
        check(wr_ready == 1'b0, "R8 write side held by read reset", wr_ready, 0);
        repeat (3) @(negedge rd_clk);
        rd_rst = 1'b0;
        repeat (6) @(negedge wr_clk);
        check(wr_ready == 1'b1, "R8 write side back", wr_ready, 1);

        // R9: buffered variant
        @(negedge rd_clk);
        wr_rst_b = 1'b0;
        rd_rst_b = 1'b0;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge rd_clk);
            if (rd_was_reset_b) cnt++;
        end
        check(cnt == 4, "R9 flag cycles buffered", cnt, 4);
        check(rd_valid_b == 1'b0, "R9 empty after reset", rd_valid_b, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge wr_clk);
            wr_data_b = DW'(8'h11 * (k + 1));
            wr_en_b   = 1'b1;
        end
        @(negedge wr_clk);
        wr_en_b = 1'b0;
        for (int k = 0; k < 40 && !rd_valid_b; k++) @(negedge rd_clk);
        repeat (4) @(negedge rd_clk);
        check(rd_valid_b == 1'b1 && rd_data_b == 8'h11, "R9 head without strobe", rd_data_b, 'h11);
        for (int k = 0; k < 3; k++) begin
            for (int g = 0; g < 40 && !rd_valid_b; g++) @(negedge rd_clk);
            check(rd_data_b == DW'(8'h11 * (k + 1)), "R9 buffered order", rd_data_b, 8'h11 * (k + 1));
            rd_en_b = 1'b1;
            @(negedge rd_clk);
            rd_en_b = 1'b0;
        end
        repeat (8) @(negedge rd_clk);
        check(rd_valid_b == 1'b0, "R9 drained", rd_valid_b, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule